// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the control pins of an asynchronous, address-multiplexed DRAM interface: row strobe, column strobe, two byte write enables and output enable. It samples them with a fast local clock and decides what kind of memory cycle the controller has just run. It does not need a command bus. The cycle type comes only from the order in which the strobe and enable edges arrive. Every input first passes through a two-stage synchroniser, so ordering is judged in sample clocks and never in nanoseconds.

Each row-strobe period ends when the row strobe rises. At that point the block emits a one-clock report that carries a cycle code, the row address taken when the row strobe fell, and the column address taken at the most recent column-strobe fall. Write cycles whose enable timing fits neither the early-write nor the read-modify-write order are reported as indeterminate and are flagged. The block can sit beside a controller in a simulation or be built into hardware as a protocol monitor.

Top module: `dram_cycle_classifier`

## Requirements
- R1: After reset, `cyc_valid` and `cyc_ambig` are low and `cyc_code` reads 0 (standby).
- R2: A report is a single-clock pulse on `cyc_valid`. It is visible in the third clock after the clock edge that first samples `ras_n` high. `cyc_code` reads 0 whenever `cyc_valid` is low.
- R3: A row strobe fall, then one column strobe fall with both write enables high, and no later write-enable fall, gives code 1 (word read).
- R4: If a write enable is already low when the column strobe falls, the cycle is an early write. Both enables low gives code 2 (word), only `wu_n` low gives code 3 (upper byte), and only `wl_n` low gives code 4 (lower byte).
- R5: A write enable that falls after the column strobe fell, and after `oe_n` was seen low with the column strobe low, gives code 5 (read-modify-write).
- R6: A write enable that falls after the column strobe fell, with no prior output-enable read, gives code 10 (indeterminate) and raises `cyc_ambig` together with `cyc_valid`. `cyc_ambig` is low for every other code.
- R7: Two or more column strobe falls within one row strobe low period give code 6 (page mode). The reported column is the one captured at the last column-strobe fall.
- R8: A column strobe that is low when the row strobe falls, having fallen while the row strobe was high, gives code 7 (column-before-row refresh).
- R9: A row strobe period with no column strobe fall gives code 8 (row-only refresh), and the captured row is reported.
- R10: A column strobe held low across a row strobe rise and the following fall gives code 9 (hidden refresh) for that second row strobe period. The column reported is the one from the preceding access.
- R11: The row is the `addr` value sampled at the row-strobe fall, and the column is the `addr` value sampled at the column-strobe fall. Both are presented on `cyc_row` and `cyc_col` during the report pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| wu_n | input | 1 | Upper byte write enable, active low |
| wl_n | input | 1 | Lower byte write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed address pins |
| cyc_valid | output | 1 | One-clock report strobe |
| cyc_code | output | 4 | Cycle class code |
| cyc_row | output | ADDR_W | Captured row address |
| cyc_col | output | ADDR_W | Captured column address |
| cyc_ambig | output | 1 | Indeterminate write timing flag |

## Verification
The bench sets read-modify-write against the indeterminate late write. The two differ only in whether output enable went low before the write enable fell, so a design that ignores that history would report one as the other. The bench also separates column-before-row refresh from hidden refresh: in both, the column strobe is low at the row-strobe fall, and only the history of when the column strobe went low tells them apart. A design that merged the two would return the wrong refresh code. A page with three column pulses checks that a design latching the first column, or counting only one fall, is caught. The one-clock width and the exact latency of each report are measured on every cycle.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [3:0] {
    CK_STANDBY  = 4'd0,
    CK_READ     = 4'd1,
    CK_WR_WORD  = 4'd2,
    CK_WR_UPPER = 4'd3,
    CK_WR_LOWER = 4'd4,
    CK_RMW      = 4'd5,
    CK_PAGE     = 4'd6,
    CK_CBR      = 4'd7,
    CK_ROR      = 4'd8,
    CK_HIDDEN   = 4'd9,
    CK_INDET    = 4'd10
  } cyc_kind_e;

  localparam int unsigned CAS_CNT_W = 2;

  typedef struct packed {
    logic                 cas_held;  // column strobe stayed low across a row rise
    logic                 rf_cbr;    // column low at row fall, fresh
    logic                 rf_hid;    // column low at row fall, carried over
    logic [CAS_CNT_W-1:0] cas_cnt;   // saturating column fall count
    logic                 early;
    logic                 ew_u;
    logic                 ew_l;
    logic                 oe_rd;     // output enable seen during column low
    logic                 late_ok;
    logic                 late_bad;
  } trk_state_t;

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/dsc_track.sv
module dsc_track
  import dsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_s,
  input  logic              cas_s,
  input  logic              wu_s,
  input  logic              wl_s,
  input  logic              oe_s,
  input  logic [ADDR_W-1:0] addr_s,
  output logic              rep_valid,
  output cyc_kind_e         rep_code,
  output logic [ADDR_W-1:0] rep_row,
  output logic [ADDR_W-1:0] rep_col
);

  localparam logic [CAS_CNT_W-1:0] CNT_MAX = {CAS_CNT_W{1'b1}};

  logic ras_p, cas_p, wu_p, wl_p;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, in_row;

  trk_state_t         st_q, st_d;
  logic [ADDR_W-1:0]  row_q, row_d, col_q, col_d;
  logic               vld_q, vld_d;
  cyc_kind_e          code_q, code_d, cls;
  logic [ADDR_W-1:0]  rrow_q, rcol_q;

  assign ras_fall = ras_p & ~ras_s;
  assign ras_rise = ~ras_p & ras_s;
  assign cas_fall = cas_p & ~cas_s;
  assign cas_rise = ~cas_p & cas_s;
  assign we_fall  = (wu_p & ~wu_s) | (wl_p & ~wl_s);
  assign in_row   = ~ras_s;

  // state update
  always_comb begin
    st_d  = st_q;
    row_d = row_q;
    col_d = col_q;
    if (ras_fall) begin
      st_d.rf_cbr   = ~cas_s & ~st_q.cas_held;
      st_d.rf_hid   = ~cas_s & st_q.cas_held;
      st_d.cas_cnt  = '0;
      st_d.early    = 1'b0;
      st_d.ew_u     = 1'b0;
      st_d.ew_l     = 1'b0;
      st_d.oe_rd    = 1'b0;
      st_d.late_ok  = 1'b0;
      st_d.late_bad = 1'b0;
      row_d         = addr_s;
    end
    if (cas_rise) st_d.cas_held = 1'b0;
    if (ras_rise && !cas_s) st_d.cas_held = 1'b1;
    if (in_row && cas_fall) begin
      col_d = addr_s;
      if (st_d.cas_cnt == '0 && (!wu_s || !wl_s)) begin
        st_d.early = 1'b1;
        st_d.ew_u  = ~wu_s;
        st_d.ew_l  = ~wl_s;
      end
      if (st_d.cas_cnt != CNT_MAX) st_d.cas_cnt = st_d.cas_cnt + 1'b1;
    end
    if (in_row && !cas_s && !oe_s) st_d.oe_rd = 1'b1;
    if (in_row && !cas_s && we_fall && !ras_fall && st_q.cas_cnt != '0 &&
        !st_d.early && !st_d.late_ok && !st_d.late_bad) begin
      if (st_d.oe_rd) st_d.late_ok  = 1'b1;
      else            st_d.late_bad = 1'b1;
    end
  end

  // classification of the closing row period
  always_comb begin
    if (st_q.rf_hid)                  cls = CK_HIDDEN;
    else if (st_q.rf_cbr)             cls = CK_CBR;
    else if (st_q.cas_cnt == '0)      cls = CK_ROR;
    else if (st_q.cas_cnt > 1)        cls = CK_PAGE;
    else if (st_q.early) begin
      if (st_q.ew_u && st_q.ew_l)     cls = CK_WR_WORD;
      else if (st_q.ew_u)             cls = CK_WR_UPPER;
      else                            cls = CK_WR_LOWER;
    end
    else if (st_q.late_bad)           cls = CK_INDET;
    else if (st_q.late_ok)            cls = CK_RMW;
    else                              cls = CK_READ;
    vld_d  = ras_rise;
    code_d = ras_rise ? cls : CK_STANDBY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p  <= 1'b1;
      cas_p  <= 1'b1;
      wu_p   <= 1'b1;
      wl_p   <= 1'b1;
      st_q   <= '0;
      row_q  <= '0;
      col_q  <= '0;
      vld_q  <= 1'b0;
      code_q <= CK_STANDBY;
      rrow_q <= '0;
      rcol_q <= '0;
    end else begin
      ras_p  <= ras_s;
      cas_p  <= cas_s;
      wu_p   <= wu_s;
      wl_p   <= wl_s;
      st_q   <= st_d;
      row_q  <= row_d;
      col_q  <= col_d;
      vld_q  <= vld_d;
      code_q <= code_d;
      if (ras_rise) begin
        rrow_q <= row_q;
        rcol_q <= col_q;
      end
    end
  end

  assign rep_valid = vld_q;
  assign rep_code  = code_q;
  assign rep_row   = rrow_q;
  assign rep_col   = rcol_q;

  // R2: report is a single clock wide
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R2: report only follows a synchronised row strobe rise
  a_r2_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(ras_rise));

  // R6: early, good late and bad late writes are exclusive
  a_r6_write_kind_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_q.early, st_q.late_ok, st_q.late_bad}));

  // R8: a row period cannot be both refresh kinds
  a_r8_refresh_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_q.rf_cbr && st_q.rf_hid));

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
  import dsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              wu_n,
  input  logic              wl_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cyc_valid,
  output logic [3:0]        cyc_code,
  output logic [ADDR_W-1:0] cyc_row,
  output logic [ADDR_W-1:0] cyc_col,
  output logic              cyc_ambig
);

  localparam int unsigned CTL_W = 5;

  logic             rst_meta, rst_sync;
  logic [CTL_W-1:0] ctl_s;
  logic [ADDR_W-1:0] addr_s;
  cyc_kind_e        code;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  dsc_sync #(.W(CTL_W), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
    .clk   (clk),
    .rst_n (rst_sync),
    .d     ({ras_n, cas_n, wu_n, wl_n, oe_n}),
    .q     (ctl_s)
  );

  dsc_sync #(.W(ADDR_W), .RST_VAL('0)) u_sync_addr (
    .clk   (clk),
    .rst_n (rst_sync),
    .d     (addr),
    .q     (addr_s)
  );

  dsc_track #(.ADDR_W(ADDR_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_sync),
    .ras_s     (ctl_s[4]),
    .cas_s     (ctl_s[3]),
    .wu_s      (ctl_s[2]),
    .wl_s      (ctl_s[1]),
    .oe_s      (ctl_s[0]),
    .addr_s    (addr_s),
    .rep_valid (cyc_valid),
    .rep_code  (code),
    .rep_row   (cyc_row),
    .rep_col   (cyc_col)
  );

  assign cyc_code  = code;
  assign cyc_ambig = cyc_valid && (code == CK_INDET);

  // R2: a valid report never carries the idle code
  a_r2_no_standby_report: assert property (@(posedge clk) disable iff (!rst_sync)
    cyc_valid |-> (cyc_code != CK_STANDBY));

endmodule

// File: tb/dram_cycle_classifier_tb.sv
module dram_cycle_classifier_tb;

  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ras_n, cas_n, wu_n, wl_n, oe_n;
  logic [AW-1:0] addr;
  logic cyc_valid, cyc_ambig;
  logic [3:0] cyc_code;
  logic [AW-1:0] cyc_row, cyc_col;

  int total = 0;
  int bad   = 0;
  logic [AW-1:0] last_col;
  bit done = 0;

  always #4 clk = ~clk;

  dram_cycle_classifier #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .wu_n(wu_n),
    .wl_n(wl_n), .oe_n(oe_n), .addr(addr), .cyc_valid(cyc_valid),
    .cyc_code(cyc_code), .cyc_row(cyc_row), .cyc_col(cyc_col), .cyc_ambig(cyc_ambig)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raise row strobe at a negedge and check the report
  task automatic close_row(input string tag, input int code, input int row,
                           input int col, input bit chk_col);
    ras_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk(cyc_valid == 1'b1, {tag, " R2 valid latency"}, cyc_valid, 1);
    chk(cyc_code == code[3:0], {tag, " code"}, cyc_code, code);
    chk(cyc_ambig == (code == 10), {tag, " R6 ambig"}, cyc_ambig, code == 10);
    chk(cyc_row == row[AW-1:0], {tag, " R11 row"}, cyc_row, row);
    if (chk_col) chk(cyc_col == col[AW-1:0], {tag, " R11 col"}, cyc_col, col);
    @(posedge clk);
    #2;
    chk(cyc_valid == 1'b0, {tag, " R2 one clock"}, cyc_valid, 0);
    chk(cyc_code == 4'd0, {tag, " R2 idle code"}, cyc_code, 0);
    hold(3);
  endtask

  task automatic open_row(input int row);
    addr = row[AW-1:0];
    ras_n = 1'b0;
    hold(3);
  endtask

  task automatic t_reset;
    hold(1);
    chk(cyc_valid == 1'b0, "R1 valid", cyc_valid, 0);
    chk(cyc_code == 4'd0, "R1 code", cyc_code, 0);
    chk(cyc_ambig == 1'b0, "R1 ambig", cyc_ambig, 0);
  endtask

  task automatic t_read;
    open_row(8'h12);
    addr = 8'h34; cas_n = 1'b0; oe_n = 1'b0; hold(3);
    cas_n = 1'b1; oe_n = 1'b1; hold(2);
    close_row("R3 read", 1, 8'h12, 8'h34, 1);
    last_col = 8'h34;
  endtask

  task automatic t_early(input logic u, input logic l, input int code, input string tag);
    open_row(8'h40 + code);
    wu_n = u; wl_n = l; hold(3);
    addr = 8'h80 + code; cas_n = 1'b0; hold(3);
    cas_n = 1'b1; wu_n = 1'b1; wl_n = 1'b1; hold(2);
    close_row(tag, code, 8'h40 + code, 8'h80 + code, 1);
    last_col = 8'h80 + code;
  endtask

  task automatic t_late(input bit with_oe);
    open_row(8'h55);
    addr = 8'h66; cas_n = 1'b0; oe_n = with_oe ? 1'b0 : 1'b1; hold(3);
    oe_n = 1'b1; hold(2);
    wu_n = 1'b0; wl_n = 1'b0; hold(3);
    cas_n = 1'b1; wu_n = 1'b1; wl_n = 1'b1; hold(2);
    if (with_oe) close_row("R5 rmw", 5, 8'h55, 8'h66, 1);
    else         close_row("R6 indeterminate", 10, 8'h55, 8'h66, 1);
    last_col = 8'h66;
  endtask

  task automatic t_page;
    open_row(8'h70);
    for (int i = 0; i < 3; i++) begin
      addr = 8'hA0 + i; cas_n = 1'b0; oe_n = 1'b0; hold(3);
      cas_n = 1'b1; hold(3);
    end
    oe_n = 1'b1;
    close_row("R7 page", 6, 8'h70, 8'hA2, 1);
    last_col = 8'hA2;
  endtask

  task automatic t_cbr;
    cas_n = 1'b0; hold(3);
    open_row(8'h91);
    cas_n = 1'b1; hold(3);
    close_row("R8 cbr", 7, 8'h91, last_col, 1);
  endtask

  task automatic t_ror;
    open_row(8'h3C);
    hold(2);
    close_row("R9 ror", 8, 8'h3C, last_col, 1);
  endtask

  task automatic t_hidden;
    open_row(8'h21);
    addr = 8'h43; cas_n = 1'b0; oe_n = 1'b0; hold(3);
    close_row("R10 lead read", 1, 8'h21, 8'h43, 1);
    open_row(8'hC5);
    close_row("R10 hidden", 9, 8'hC5, 8'h43, 1);
    cas_n = 1'b1; oe_n = 1'b1; hold(3);
    last_col = 8'h43;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ras_n = 1'b1; cas_n = 1'b1; wu_n = 1'b1; wl_n = 1'b1; oe_n = 1'b1;
    addr = '0;
    last_col = '0;
    hold(3);
    rst_n = 1'b1;
    hold(4);
    t_reset;
    t_read;
    t_early(1'b0, 1'b0, 2, "R4 word write");
    t_early(1'b0, 1'b1, 3, "R4 upper write");
    t_early(1'b1, 1'b0, 4, "R4 lower write");
    t_late(1'b1);
    t_late(1'b0);
    t_page;
    t_cbr;
    t_ror;
    t_hidden;
    t_ror;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule